// File: doc/BRIEF.md
# Non-Maskable Property Register Bank for Extended Shared Interrupts

This block holds one non-maskable flag for each interrupt in an extended shared-interrupt range, packed 32 flags to a 32-bit register. Software reaches the flags over a simple register bus that carries address, read and write strobes, write data, byte enables and a flag that marks the access as non-secure. The bank exports the whole flag vector in parallel to the priority logic, so a flag that is set marks its interrupt as non-maskable and a cleared flag marks it as ordinary.

The bank does more than store and return words. Whether each flag can be read or written depends on several inputs: whether the extended range is supported at all, how many registers are implemented, whether the interrupt itself exists, the interrupt's group and security, the security of the access, a flag that collapses the two security states into one, and the affinity-routing enables of each security state. These gates are evaluated again on every cycle. A reconfiguration therefore reaches the exported vector without any software write, and the stored flag is kept underneath the mask.

Top module: `nmi_prop_bank`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, all stored flags are zero, `nmi_vec` is all zero and `rd_valid` is low.
- R2: Register n, for 0 <= n < NUM_REGS, is at byte address 0x3B00 + 4*n. Bit b of register n is the flag of interrupt ID 4096 + 32*n + b, and that flag also appears on `nmi_vec[32*n + b]`.
- R3: A write changes only the bytes whose `bus_be` bit is set: `bus_be[k]` enables `bus_wdata[8k+7:8k]`.
- R4: When `ext_en` is 0, every register reads as zero, writes change no stored flag, and `nmi_vec` is all zero.
- R5: Registers with an index greater than `ext_range` read as zero and ignore writes. So do flags whose `irq_impl` bit is 0.
- R6: A flag whose `irq_grp` bit is 0 (Group 0) reads as zero, cannot be set, and shows as 0 on `nmi_vec`.
- R7: An interrupt is secure when `ss_disable` is 0 and `irq_gsec` is 1. When `ss_disable` is 1, affinity routing for every interrupt follows `are_s`. Otherwise secure interrupts follow `are_s` and non-secure interrupts follow `are_ns`. A flag whose governing enable is 0 reads as zero and ignores writes.
- R8: When `ss_disable` is 0, a non-secure access (`bus_nonsec` = 1) reads zero from the flags of secure interrupts and cannot change them. Secure accesses are not restricted by this rule.
- R9: `nmi_vec` is registered and equals each stored flag ANDed with the flag's current gates (R4 to R7). A write shows on `nmi_vec` at the same clock edge that stores it. A change of configuration shows at the next edge. A masked flag keeps its stored value and reappears when the mask is lifted.
- R10: An access to an address outside the bank, or one whose two low address bits are not 00, reads as zero and changes nothing.
- R11: A read request sampled at a clock edge produces `rd_valid` = 1 and its data after that edge. `rd_valid` is 0 after an edge where no read was requested.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_rd | input | 1 | Read request |
| bus_wr | input | 1 | Write request |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables for the write |
| bus_nonsec | input | 1 | Access is non-secure |
| ext_en | input | 1 | Extended range supported |
| ext_range | input | IDX_W | Index of the last implemented register |
| irq_impl | input | 32*NUM_REGS | Interrupt exists |
| irq_grp | input | 32*NUM_REGS | 0 = Group 0, 1 = Group 1 |
| irq_gsec | input | 32*NUM_REGS | Group 1 interrupt is secure |
| ss_disable | input | 1 | Single security state |
| are_s | input | 1 | Affinity routing enabled, secure state |
| are_ns | input | 1 | Affinity routing enabled, non-secure state |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| nmi_vec | output | 32*NUM_REGS | Gated non-maskable flag per interrupt |

## Verification
The hold-steady property assumes that a write is the only way the flags can change apart from the configuration inputs, and that those inputs do not move on the cycle being checked. The stimulus changes configuration only on idle cycles between transactions. The bench never raises `bus_rd` and `bus_wr` together, so a read never has to observe a write made in the same cycle. The Group 0 and implemented-interrupt properties take the previous cycle's configuration as the reference for the registered vector, and the bench holds `rst` high from time zero so that this reference is defined.

// File: rtl/nmi_pkg.sv
package nmi_pkg;

  localparam int WORD_W = 32;
  localparam int BYTE_N = WORD_W / 8;

  // bus operation seen on one cycle, bit 1 = write, bit 0 = read
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_BOTH  = 2'd3
  } bus_op_e;

  typedef struct packed {
    logic    hit;
    bus_op_e op;
  } dec_info_t;

  function automatic logic [WORD_W-1:0] strobe_to_mask(input logic [BYTE_N-1:0] be);
    logic [WORD_W-1:0] m;
    for (int k = 0; k < BYTE_N; k++) begin
      m[k*8 +: 8] = {8{be[k]}};
    end
    return m;
  endfunction

  function automatic logic op_is_write(input bus_op_e op);
    return (op == OP_WRITE) || (op == OP_BOTH);
  endfunction

  function automatic logic op_is_read(input bus_op_e op);
    return (op == OP_READ) || (op == OP_BOTH);
  endfunction

endpackage

// File: rtl/nmi_addr_dec.sv
module nmi_addr_dec
  import nmi_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int NUM_REGS = 32,
  parameter int BASE_OFF = 32'h3B00,
  parameter int IDX_W    = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output dec_info_t         info,
  output logic [IDX_W-1:0]  idx
);

  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_OFF);
  localparam logic [ADDR_W-1:0] SPAN   = ADDR_W'(NUM_REGS * BYTE_N);

  logic [ADDR_W-1:0] offs;
  logic              aligned;

  always_comb begin
    offs     = addr - BASE_A;
    aligned  = (addr[1:0] == 2'b00);
    info.hit = (addr >= BASE_A) && (offs < SPAN) && aligned;
    info.op  = bus_op_e'({wr, rd});
    idx      = offs[2 +: IDX_W];
  end

endmodule

// File: rtl/nmi_bit_gate.sv
module nmi_bit_gate
  import nmi_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int IDX_W    = 5,
  localparam int N_IRQ   = NUM_REGS * WORD_W
) (
  input  logic              ext_en,
  input  logic [IDX_W-1:0]  ext_range,
  input  logic [N_IRQ-1:0]  irq_impl,
  input  logic [N_IRQ-1:0]  irq_grp,
  input  logic [N_IRQ-1:0]  irq_gsec,
  input  logic              ss_disable,
  input  logic              are_s,
  input  logic              are_ns,
  input  logic              acc_nonsec,
  output logic [N_IRQ-1:0]  live,
  output logic [N_IRQ-1:0]  acc
);

  logic [NUM_REGS-1:0] reg_ok;
  logic [N_IRQ-1:0]    sec_irq;
  logic [N_IRQ-1:0]    are_ok;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    assign reg_ok[r] = ext_en && ({1'b0, ext_range} >= (IDX_W+1)'(r));

    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
      localparam int I = r * WORD_W + b;
      // secure only when two security states exist and the group-1 interrupt is secure
      assign sec_irq[I] = ~ss_disable & irq_gsec[I];
      // single-state or secure interrupts follow the secure routing enable
      assign are_ok[I]  = (ss_disable | irq_gsec[I]) ? are_s : are_ns;
      assign live[I]    = reg_ok[r] & irq_impl[I] & irq_grp[I] & are_ok[I];
      assign acc[I]     = live[I] & ~(acc_nonsec & sec_irq[I]);
    end
  end

endmodule

// File: rtl/nmi_store.sv
module nmi_store
  import nmi_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int IDX_W    = 5,
  localparam int N_IRQ   = NUM_REGS * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wdata,
  input  logic [BYTE_N-1:0] be,
  input  logic [N_IRQ-1:0]  acc,
  output logic [N_IRQ-1:0]  store_q,
  output logic [N_IRQ-1:0]  store_d,
  output logic [WORD_W-1:0] rd_word,
  output logic [WORD_W-1:0] rd_acc
);

  logic [WORD_W-1:0] byte_mask;

  assign byte_mask = strobe_to_mask(be);

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_word
    logic              sel;
    logic [WORD_W-1:0] upd;

    assign sel = wr_en && (idx == IDX_W'(r));
    assign upd = byte_mask & acc[r*WORD_W +: WORD_W];
    assign store_d[r*WORD_W +: WORD_W] = sel
      ? ((store_q[r*WORD_W +: WORD_W] & ~upd) | (wdata & upd))
      : store_q[r*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= '0;
    end else begin
      store_q <= store_d;
    end
  end

  assign rd_word = store_q[int'(idx)*WORD_W +: WORD_W];
  assign rd_acc  = acc[int'(idx)*WORD_W +: WORD_W];

endmodule

// File: rtl/nmi_prop_bank.sv
module nmi_prop_bank
  import nmi_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int NUM_REGS = 32,
  parameter int BASE_OFF = 32'h3B00,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int N_IRQ   = NUM_REGS * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic [BYTE_N-1:0] bus_be,
  input  logic              bus_nonsec,
  input  logic              ext_en,
  input  logic [IDX_W-1:0]  ext_range,
  input  logic [N_IRQ-1:0]  irq_impl,
  input  logic [N_IRQ-1:0]  irq_grp,
  input  logic [N_IRQ-1:0]  irq_gsec,
  input  logic              ss_disable,
  input  logic              are_s,
  input  logic              are_ns,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic [N_IRQ-1:0]  nmi_vec
);

  dec_info_t         info;
  logic [IDX_W-1:0]  idx;
  logic [N_IRQ-1:0]  live;
  logic [N_IRQ-1:0]  acc;
  logic [N_IRQ-1:0]  store_q;
  logic [N_IRQ-1:0]  store_d;
  logic [WORD_W-1:0] rd_word;
  logic [WORD_W-1:0] rd_acc;
  logic              wr_go;
  logic              rd_go;

  nmi_addr_dec #(
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_REGS),
    .BASE_OFF (BASE_OFF),
    .IDX_W    (IDX_W)
  ) u_dec (
    .addr (bus_addr),
    .rd   (bus_rd),
    .wr   (bus_wr),
    .info (info),
    .idx  (idx)
  );

  nmi_bit_gate #(
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W)
  ) u_gate (
    .ext_en     (ext_en),
    .ext_range  (ext_range),
    .irq_impl   (irq_impl),
    .irq_grp    (irq_grp),
    .irq_gsec   (irq_gsec),
    .ss_disable (ss_disable),
    .are_s      (are_s),
    .are_ns     (are_ns),
    .acc_nonsec (bus_nonsec),
    .live       (live),
    .acc        (acc)
  );

  assign wr_go = info.hit && op_is_write(info.op);
  assign rd_go = info.hit && op_is_read(info.op);

  nmi_store #(
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_go),
    .idx     (idx),
    .wdata   (bus_wdata),
    .be      (bus_be),
    .acc     (acc),
    .store_q (store_q),
    .store_d (store_d),
    .rd_word (rd_word),
    .rd_acc  (rd_acc)
  );

  // registered outputs: read port and the gated flag vector
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      nmi_vec  <= '0;
    end else begin
      rd_valid <= bus_rd;
      rd_data  <= rd_go ? (rd_word & rd_acc) : '0;
      nmi_vec  <= store_d & live;
    end
  end

endmodule

// File: rtl/nmi_prop_bank_chk.sv
module nmi_prop_bank_chk
  import nmi_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int NUM_REGS = 32,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int N_IRQ   = NUM_REGS * WORD_W
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic              ext_en,
  input logic [IDX_W-1:0]  ext_range,
  input logic [N_IRQ-1:0]  irq_impl,
  input logic [N_IRQ-1:0]  irq_grp,
  input logic [N_IRQ-1:0]  irq_gsec,
  input logic              ss_disable,
  input logic              are_s,
  input logic              are_ns,
  input logic              rd_valid,
  input logic [WORD_W-1:0] rd_data,
  input logic [N_IRQ-1:0]  nmi_vec
);

  logic             armed;
  logic [N_IRQ-1:0] grp_q;
  logic [N_IRQ-1:0] impl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed  <= 1'b0;
      grp_q  <= '0;
      impl_q <= '0;
    end else begin
      armed  <= 1'b1;
      grp_q  <= irq_grp;
      impl_q <= irq_impl;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (nmi_vec == '0) && !rd_valid);

  // R11
  read_valid_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> rd_valid);

  // R11
  no_read_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !rd_valid);

  // R4
  ext_off_vec_chk: assert property (@(posedge clk) disable iff (rst)
    !ext_en |=> (nmi_vec == '0));

  // R4
  ext_off_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !ext_en) |=> (rd_data == '0));

  // R10
  misalign_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (bus_addr[1:0] != 2'b00)) |=> (rd_data == '0));

  // R6
  group0_clear_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> ((nmi_vec & ~grp_q) == '0));

  // R5
  unimpl_clear_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> ((nmi_vec & ~impl_q) == '0));

  // R9
  vec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !bus_wr && $stable(ext_en) && $stable(ext_range) &&
     $stable(irq_impl) && $stable(irq_grp) && $stable(irq_gsec) &&
     $stable(ss_disable) && $stable(are_s) && $stable(are_ns))
    |=> $stable(nmi_vec));

endmodule

bind nmi_prop_bank nmi_prop_bank_chk #(
  .ADDR_W   (ADDR_W),
  .NUM_REGS (NUM_REGS)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_addr   (bus_addr),
  .bus_rd     (bus_rd),
  .bus_wr     (bus_wr),
  .ext_en     (ext_en),
  .ext_range  (ext_range),
  .irq_impl   (irq_impl),
  .irq_grp    (irq_grp),
  .irq_gsec   (irq_gsec),
  .ss_disable (ss_disable),
  .are_s      (are_s),
  .are_ns     (are_ns),
  .rd_valid   (rd_valid),
  .rd_data    (rd_data),
  .nmi_vec    (nmi_vec)
);

// File: tb/nmi_prop_bank_test.sv
module nmi_prop_bank_test;

  localparam int NR   = 32;
  localparam int NI   = NR * 32;
  localparam int BASE = 32'h3B00;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [15:0]   bus_addr = '0;
  logic          bus_rd = 1'b0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [3:0]    bus_be = '0;
  logic          bus_nonsec = 1'b1;
  logic          ext_en = 1'b1;
  logic [4:0]    ext_range = 5'd3;
  logic [NI-1:0] irq_impl = '1;
  logic [NI-1:0] irq_grp = '1;
  logic [NI-1:0] irq_gsec = '0;
  logic          ss_disable = 1'b0;
  logic          are_s = 1'b1;
  logic          are_ns = 1'b1;
  logic          rd_valid;
  logic [31:0]   rd_data;
  logic [NI-1:0] nmi_vec;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nmi_prop_bank uut (
    .clk (clk), .rst (rst), .bus_addr (bus_addr), .bus_rd (bus_rd),
    .bus_wr (bus_wr), .bus_wdata (bus_wdata), .bus_be (bus_be),
    .bus_nonsec (bus_nonsec), .ext_en (ext_en), .ext_range (ext_range),
    .irq_impl (irq_impl), .irq_grp (irq_grp), .irq_gsec (irq_gsec),
    .ss_disable (ss_disable), .are_s (are_s), .are_ns (are_ns),
    .rd_valid (rd_valid), .rd_data (rd_data), .nmi_vec (nmi_vec)
  );

  // ---------------- behavioural reference model ----------------
  logic [NI-1:0] m_store;
  logic [NI-1:0] m_nmi;
  logic          m_rv;
  logic [31:0]   m_rd;
  int            m_a;
  int            m_r;
  bit            m_hit;

  function automatic bit m_live(int i);
    bit are_ok;
    are_ok = (ss_disable || irq_gsec[i]) ? are_s : are_ns;
    return ext_en && ((i / 32) <= int'(ext_range)) && irq_impl[i] && irq_grp[i] && are_ok;
  endfunction

  function automatic bit m_acc(int i, bit ns);
    return m_live(i) && !(ns && !ss_disable && irq_gsec[i]);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_store = '0;
      m_nmi   = '0;
      m_rv    = 1'b0;
      m_rd    = '0;
    end else begin
      m_a   = int'(bus_addr);
      m_hit = (m_a >= BASE) && (m_a < BASE + 4 * NR) && (m_a % 4 == 0);
      m_r   = (m_a - BASE) / 4;
      m_rv  = bus_rd;
      m_rd  = '0;
      if (bus_rd && m_hit)
        for (int b = 0; b < 32; b++)
          if (m_acc(m_r * 32 + b, bus_nonsec)) m_rd[b] = m_store[m_r * 32 + b];
      if (bus_wr && m_hit)
        for (int b = 0; b < 32; b++)
          if (bus_be[b / 8] && m_acc(m_r * 32 + b, bus_nonsec))
            m_store[m_r * 32 + b] = bus_wdata[b];
      for (int i = 0; i < NI; i++) m_nmi[i] = m_store[i] && m_live(i);
    end
  end

  // compare against the model on every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (nmi_vec !== m_nmi) begin
        errors++;
        for (int i = 0; i < NI; i++)
          if (nmi_vec[i] !== m_nmi[i]) begin
            $display("FAIL R9 nmi_vec[%0d] act=%b exp=%b", i, nmi_vec[i], m_nmi[i]);
            break;
          end
      end
      checks++;
      if (rd_valid !== m_rv) begin
        errors++;
        $display("FAIL R11 rd_valid act=%b exp=%b", rd_valid, m_rv);
      end
      if (m_rv) begin
        checks++;
        if (rd_data !== m_rd) begin
          errors++;
          $display("FAIL R2 rd_data act=%h exp=%h", rd_data, m_rd);
        end
      end
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic wr(input int addr, input logic [31:0] data, input logic [3:0] be, input bit ns);
    @(negedge clk);
    bus_addr = 16'(addr); bus_wdata = data; bus_be = be; bus_nonsec = ns; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int addr, input bit ns, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = 16'(addr); bus_nonsec = ns; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check(rd_valid === 1'b1, "R11 rd_valid", 32'(rd_valid), 32'd1);
    check(rd_data === exp, tag, rd_data, exp);
  endtask

  task automatic vec_word(input int r, input logic [31:0] exp, input string tag);
    @(negedge clk);
    check(nmi_vec[r*32 +: 32] === exp, tag, nmi_vec[r*32 +: 32], exp);
  endtask

  initial begin
    irq_impl[100] = 1'b0;
    repeat (4) @(negedge clk);
    // R1: state held in reset
    check(nmi_vec === '0, "R1 nmi_vec in reset", 32'(nmi_vec[31:0]), 32'h0);
    check(rd_valid === 1'b0, "R1 rd_valid in reset", 32'(rd_valid), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check(nmi_vec === '0, "R1 nmi_vec after reset", 32'(nmi_vec[31:0]), 32'h0);

    // R2: full word write and read back, vector position
    wr(BASE, 32'hA5A5_1234, 4'hF, 1'b1);
    rd(BASE, 1'b1, 32'hA5A5_1234, "R2 reg0 read");
    vec_word(0, 32'hA5A5_1234, "R2 nmi_vec word0");

    // R3: byte strobes
    wr(BASE + 8, 32'hFFFF_FFFF, 4'b0101, 1'b1);
    rd(BASE + 8, 1'b1, 32'h00FF_00FF, "R3 partial strobe");

    // R5: register beyond the range, and an unimplemented interrupt
    wr(BASE + 20, 32'hFFFF_FFFF, 4'hF, 1'b1);
    rd(BASE + 20, 1'b1, 32'h0, "R5 reg above range");
    wr(BASE + 12, 32'hFFFF_FFFF, 4'hF, 1'b1);
    rd(BASE + 12, 1'b1, 32'hFFFF_FFEF, "R5 unimplemented bit");
    ext_range = 5'd1;
    idle();
    rd(BASE + 8, 1'b1, 32'h0, "R5 range shrunk");
    vec_word(2, 32'h0, "R5 vector after range shrink");
    ext_range = 5'd3;
    idle();

    // R6 and R9: group 0 masking without a write, then restored
    irq_grp[2] = 1'b0;
    idle();
    rd(BASE, 1'b1, 32'hA5A5_1230, "R6 group0 read");
    vec_word(0, 32'hA5A5_1230, "R9 group0 vector");
    irq_grp[32] = 1'b0;
    wr(BASE + 4, 32'h0000_0001, 4'hF, 1'b1);
    irq_grp[2] = 1'b1;
    irq_grp[32] = 1'b1;
    idle();
    rd(BASE, 1'b1, 32'hA5A5_1234, "R9 retained flag");
    rd(BASE + 4, 1'b1, 32'h0, "R6 group0 not settable");

    // R7: affinity routing enables
    are_ns = 1'b0;
    idle();
    rd(BASE, 1'b1, 32'h0, "R7 ns routing off");
    vec_word(0, 32'h0, "R7 vector routing off");
    are_ns = 1'b1;
    are_s  = 1'b0;
    idle();
    rd(BASE, 1'b1, 32'hA5A5_1234, "R7 ns follows own enable");
    are_s = 1'b1;
    idle();

    // R8: secure interrupt vs non-secure access
    irq_gsec[40] = 1'b1;
    wr(BASE + 4, 32'h0000_0100, 4'hF, 1'b1);
    rd(BASE + 4, 1'b0, 32'h0, "R8 ns write ignored");
    wr(BASE + 4, 32'h0000_0100, 4'hF, 1'b0);
    rd(BASE + 4, 1'b0, 32'h0000_0100, "R8 secure write");
    rd(BASE + 4, 1'b1, 32'h0, "R8 ns read hidden");
    ss_disable = 1'b1;
    idle();
    rd(BASE + 4, 1'b1, 32'h0000_0100, "R8 single state ns read");
    ss_disable = 1'b0;
    idle();

    // R4: extended range disabled
    ext_en = 1'b0;
    idle();
    rd(BASE, 1'b0, 32'h0, "R4 read with range off");
    vec_word(0, 32'h0, "R4 vector with range off");
    wr(BASE, 32'h0, 4'hF, 1'b0);
    ext_en = 1'b1;
    idle();
    rd(BASE, 1'b0, 32'hA5A5_1234, "R4 write ignored");

    // R10: misaligned and out-of-bank accesses
    rd(BASE + 1, 1'b0, 32'h0, "R10 misaligned read");
    wr(BASE + 2, 32'h0, 4'hF, 1'b0);
    rd(BASE, 1'b0, 32'hA5A5_1234, "R10 misaligned write ignored");
    rd(BASE + 4 * NR, 1'b0, 32'h0, "R10 read past bank");
    rd(BASE - 4, 1'b0, 32'h0, "R10 read below bank");

    repeat (3) idle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule